// File: doc/BRIEF.md
# Dual Programmable Interval Timer

This block contains two interval timers, A and B. Each one counts down toward overflow at its own fixed fraction of the master clock. Software programs a preset for each timer and a control byte through a narrow register-write port. While a timer runs, it counts ticks from its preset until it passes zero. At that point it sends out a one-cycle overflow strobe and reloads its preset by itself, so it produces a steady train of strobes.

A single free-running prescaler divides the master clock by 144 to make the timer A tick. Timer B advances on every sixteenth of those ticks, which is once per 2304 master clocks. Timer A has a 10-bit preset held in two separate registers. Timer B has an 8-bit preset. A new preset takes effect at the next overflow or load, and the two halves of timer A's preset are not latched together.

The overflow strobes and the whole control byte go to a separate interrupt/status block. That block uses the enable and reset bits of the control byte; this timer block does not act on them. Bus-side latching and status readback are handled elsewhere.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset, `ctrlOut` is 0, all presets are 0, both timers are stopped, and no overflow strobe is produced.
- R2: While timer A runs with preset NA, consecutive `ovfA` strobes are exactly 144 × (1024 − NA) clock cycles apart. NA = 1023 gives 144 cycles.
- R3: While timer B runs with preset NB, consecutive `ovfB` strobes are exactly 2304 × (256 − NB) clock cycles apart.
- R4: Each overflow strobe is high for exactly one clock cycle.
- R5: Control register address 0x27: bit 0 runs timer A and bit 1 runs timer B. A write that changes a run bit from 0 to 1 loads that timer's preset and starts it. A write that leaves a run bit at 1 does not reload or restart that timer.
- R6: While a timer's run bit is 0, that timer produces no overflow strobes.
- R7: Timer A's preset NA is built from two registers. Address 0x24 holds NA bits 9:2, and data bits 1:0 written to address 0x25 become NA bits 1:0. Each write updates only its own bits, and the order of the two writes does not matter. The new value is used at the next overflow reload or the next load, and the period already in progress is not changed.
- R8: Address 0x26 holds timer B's preset NB. NB is used at the next overflow reload or load.
- R9: `ctrlOut` presents all 8 bits last written to address 0x27 from the cycle after the write. Bits 2 to 7 are passed to the interrupt block with no effect on counting.
- R10: Writes to any address other than 0x24 to 0x27 change neither `ctrlOut` nor the timing of either timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Register write address |
| wrData | input | 8 | Register write data |
| ovfA | output | 1 | One-cycle overflow strobe of timer A |
| ovfB | output | 1 | One-cycle overflow strobe of timer B |
| ctrlOut | output | 8 | Current control byte, for the interrupt block |

## Verification
The bench rewrites the two halves of timer A's preset in both orders while the timer is running. A design that latched the halves together, or used a new value before the next overflow, would give a wrong interval. The bench also writes the run bit again while it is already set; a design that treated any 1 as a load would restart the count, and the following strobe would come late. Timer A is stopped for a long window, and a design that counted with the run bit clear would produce a strobe in that window. Finally, the bench writes to unrelated addresses, including the address just below the preset registers. A loose address decode would show up as a corrupted control byte or a shifted timer B period.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // strobes from the register side to the counting datapath
  typedef struct packed {
    logic loadA;
    logic loadB;
    logic runA;
    logic runB;
  } timer_ctl_t;
endpackage

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int A_WIDTH = 10,
  parameter int B_WIDTH = 8,
  parameter logic [7:0] ADDR_A_HI = 8'h24,
  parameter logic [7:0] ADDR_A_LO = 8'h25,
  parameter logic [7:0] ADDR_B    = 8'h26,
  parameter logic [7:0] ADDR_CTRL = 8'h27
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrEn,
  input  logic [7:0]         wrAddr,
  input  logic [7:0]         wrData,
  output logic [A_WIDTH-1:0] presetA,
  output logic [B_WIDTH-1:0] presetB,
  output logic [7:0]         ctrlReg,
  output timer_ctl_t         ctl
);
  // low part of timer A preset lives in its own register
  localparam int LO_BITS = A_WIDTH - 8;

  logic ctrlWr;
  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  // a load happens only on a 0 -> 1 change of a run bit
  always_comb begin
    ctl.loadA = ctrlWr && wrData[0] && !ctrlReg[0];
    ctl.loadB = ctrlWr && wrData[1] && !ctrlReg[1];
    ctl.runA  = ctrlReg[0];
    ctl.runB  = ctrlReg[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presetA <= '0;
      presetB <= '0;
      ctrlReg <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_A_HI: presetA[A_WIDTH-1:LO_BITS] <= wrData;
        ADDR_A_LO: presetA[LO_BITS-1:0]       <= wrData[LO_BITS-1:0];
        ADDR_B:    presetB                    <= wrData[B_WIDTH-1:0];
        ADDR_CTRL: ctrlReg                    <= wrData;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             tick,
  input  logic [WIDTH-1:0] preset,
  output logic             ovf
);
  // count holds remaining ticks minus one; inverted preset = max - preset
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      if (load) begin
        cnt <= ~preset;
      end else if (run && tick) begin
        if (cnt == '0) begin
          cnt <= ~preset;
          ovf <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int PRESCALE = 144,
  parameter int B_DIV    = 16,
  parameter int A_WIDTH  = 10,
  parameter int B_WIDTH  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  timer_ctl_t         ctl,
  input  logic [A_WIDTH-1:0] presetA,
  input  logic [B_WIDTH-1:0] presetB,
  output logic               ovfA,
  output logic               ovfB
);
  localparam int PW = $clog2(PRESCALE);
  localparam int DW = $clog2(B_DIV);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(B_DIV - 1);

  logic [PW-1:0] preCnt;
  logic [DW-1:0] subCnt;
  logic tickA, tickB;

  assign tickA = (preCnt == PRE_LAST);
  assign tickB = tickA && (subCnt == DIV_LAST);

  // free-running prescaler, independent of the run bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      subCnt <= '0;
    end else begin
      preCnt <= tickA ? '0 : preCnt + 1'b1;
      if (tickA) subCnt <= tickB ? '0 : subCnt + 1'b1;
    end
  end

  timer_counter #(.WIDTH(A_WIDTH)) u_cntA (
    .clk(clk), .rst_n(rst_n), .load(ctl.loadA), .run(ctl.runA),
    .tick(tickA), .preset(presetA), .ovf(ovfA)
  );

  timer_counter #(.WIDTH(B_WIDTH)) u_cntB (
    .clk(clk), .rst_n(rst_n), .load(ctl.loadB), .run(ctl.runB),
    .tick(tickB), .preset(presetB), .ovf(ovfB)
  );
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import timer_pkg::*;
#(
  parameter int PRESCALE = 144,
  parameter int B_DIV    = 16,
  parameter int A_WIDTH  = 10,
  parameter int B_WIDTH  = 8,
  parameter logic [7:0] ADDR_A_HI = 8'h24,
  parameter logic [7:0] ADDR_A_LO = 8'h25,
  parameter logic [7:0] ADDR_B    = 8'h26,
  parameter logic [7:0] ADDR_CTRL = 8'h27
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       ovfA,
  output logic       ovfB,
  output logic [7:0] ctrlOut
);
  timer_ctl_t ctl;
  logic [A_WIDTH-1:0] presetA;
  logic [B_WIDTH-1:0] presetB;

  timer_regs #(
    .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .ADDR_A_HI(ADDR_A_HI),
    .ADDR_A_LO(ADDR_A_LO), .ADDR_B(ADDR_B), .ADDR_CTRL(ADDR_CTRL)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .presetA(presetA), .presetB(presetB), .ctrlReg(ctrlOut), .ctl(ctl)
  );

  timer_datapath #(
    .PRESCALE(PRESCALE), .B_DIV(B_DIV), .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .presetA(presetA), .presetB(presetB),
    .ovfA(ovfA), .ovfB(ovfB)
  );
endmodule

// File: rtl/timer_checker.sv
module timer_checker #(
  parameter logic [7:0] ADDR_CTRL = 8'h27
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [7:0] wrAddr,
  input logic [7:0] wrData,
  input logic       ovfA,
  input logic       ovfB,
  input logic [7:0] ctrlOut
);
  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (ctrlOut == 8'h00 && !ovfA && !ovfB)); // R1
  AST_OVF_A_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovfA |=> !ovfA); // R4
  AST_OVF_B_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ovfB |=> !ovfB); // R4
  AST_STOPPED_A: assert property (@(posedge clk) disable iff (!rst_n) ovfA |-> $past(ctrlOut[0])); // R6
  AST_STOPPED_B: assert property (@(posedge clk) disable iff (!rst_n) ovfB |-> $past(ctrlOut[1])); // R6
  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_CTRL) |=> ctrlOut == $past(wrData)); // R9
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && wrAddr == ADDR_CTRL) |=> $stable(ctrlOut)); // R10
endmodule

bind dual_interval_timer timer_checker #(.ADDR_CTRL(ADDR_CTRL)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
  .ovfA(ovfA), .ovfB(ovfB), .ctrlOut(ctrlOut)
);

// File: tb/test_dual_interval_timer.sv
`timescale 1ns/1ps
module test_dual_interval_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrAddr = 8'h00;
  logic [7:0] wrData = 8'h00;
  logic ovfA, ovfB;
  logic [7:0] ctrlOut;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int cntA = 0;
  int cntB = 0;
  bit finished = 0;

  // reference model state (remaining ticks, not raw counters)
  int mPre, mSub, mRemA, mRemB, mNa, mNb;
  logic [7:0] mCtrl;
  bit mOvfA, mOvfB;

  dual_interval_timer i_dual_interval_timer (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .ovfA(ovfA), .ovfB(ovfB), .ctrlOut(ctrlOut)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // behavioural model, evaluated at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      mPre = 0; mSub = 0; mRemA = 0; mRemB = 0; mNa = 0; mNb = 0;
      mCtrl = 8'h00; mOvfA = 0; mOvfB = 0;
    end else begin
      bit tA, tB, ldA, ldB;
      tA = (mPre == 143);
      tB = tA && (mSub == 15);
      mPre = (mPre + 1) % 144;
      if (tA) mSub = (mSub + 1) % 16;
      ldA = wrEn && wrAddr == 8'h27 && wrData[0] && !mCtrl[0];
      ldB = wrEn && wrAddr == 8'h27 && wrData[1] && !mCtrl[1];
      mOvfA = 0;
      mOvfB = 0;
      if (ldA) mRemA = 1024 - mNa;
      else if (mCtrl[0] && tA) begin
        mRemA--;
        if (mRemA == 0) begin mOvfA = 1; mRemA = 1024 - mNa; end
      end
      if (ldB) mRemB = 256 - mNb;
      else if (mCtrl[1] && tB) begin
        mRemB--;
        if (mRemB == 0) begin mOvfB = 1; mRemB = 256 - mNb; end
      end
      if (wrEn) begin
        case (wrAddr)
          8'h24: mNa = (int'(wrData) << 2) | (mNa & 3);
          8'h25: mNa = (mNa & 1020) | (int'(wrData) & 3);
          8'h26: mNb = int'(wrData);
          8'h27: mCtrl = wrData;
          default: ;
        endcase
      end
    end
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && cyc > 2) begin
      check(ovfA == mOvfA, "R2", "ovfA vs model", int'(ovfA), int'(mOvfA));
      check(ovfB == mOvfB, "R3", "ovfB vs model", int'(ovfB), int'(mOvfB));
      check(ctrlOut == mCtrl, "R9", "ctrlOut vs model", int'(ctrlOut), int'(mCtrl));
    end
    if (ovfA) cntA++;
    if (ovfB) cntB++;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic waitOvfA(output int c);
    do @(negedge clk); while (!ovfA);
    c = cyc;
  endtask

  task automatic waitOvfB(output int c);
    do @(negedge clk); while (!ovfB);
    c = cyc;
  endtask

  initial begin
    int c1, c2, snap;
    repeat (4) @(negedge clk);
    check(ctrlOut == 8'h00, "R1", "ctrlOut in reset", int'(ctrlOut), 0);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    #1;
    check(cntA == 0 && cntB == 0, "R1", "strobes after reset", cntA + cntB, 0);

    // R2: shortest period
    wr(8'h24, 8'hFF); wr(8'h25, 8'h03); wr(8'h27, 8'h01);
    waitOvfA(c1); waitOvfA(c2);
    check(c2 - c1 == 144, "R2", "period NA=1023", c2 - c1, 144);
    @(negedge clk);
    check(ovfA == 1'b0, "R4", "ovfA width", int'(ovfA), 0);

    // R7: high half then low half, NA=1020
    wr(8'h24, 8'hFF); wr(8'h25, 8'h00);
    waitOvfA(c1); waitOvfA(c2);
    check(c2 - c1 == 576, "R7", "period NA=1020 hi-then-lo", c2 - c1, 576);
    // R7: low half then high half, NA=1017
    wr(8'h25, 8'h01); wr(8'h24, 8'hFE);
    waitOvfA(c1); waitOvfA(c2);
    check(c2 - c1 == 1008, "R7", "period NA=1017 lo-then-hi", c2 - c1, 1008);

    // R5: rewriting a set run bit must not restart the count
    waitOvfA(c1);
    repeat (300) @(negedge clk);
    wr(8'h27, 8'h01);
    waitOvfA(c2);
    check(c2 - c1 == 1008, "R5", "no reload on 1->1", c2 - c1, 1008);
    // R5: a 0->1 transition reloads (timing checked by the model)
    wr(8'h27, 8'h00); repeat (50) @(negedge clk); wr(8'h27, 8'h01);
    waitOvfA(c1); waitOvfA(c2);
    check(c2 - c1 == 1008, "R5", "period after reload", c2 - c1, 1008);

    // R6: stop timer A
    wr(8'h27, 8'h00);
    #1 snap = cntA;
    repeat (3000) @(negedge clk);
    #1;
    check(cntA == snap, "R6", "strobes while stopped", cntA - snap, 0);

    // R3/R8: timer B
    wr(8'h26, 8'hFF); wr(8'h27, 8'h02);
    waitOvfB(c1); waitOvfB(c2);
    check(c2 - c1 == 2304, "R3", "period NB=255", c2 - c1, 2304);
    @(negedge clk);
    check(ovfB == 1'b0, "R4", "ovfB width", int'(ovfB), 0);
    wr(8'h26, 8'hFE);
    waitOvfB(c1); waitOvfB(c2);
    check(c2 - c1 == 4608, "R8", "period NB=254", c2 - c1, 4608);
    #1;
    check(cntA == snap, "R6", "timer A still silent", cntA - snap, 0);

    // R10: unrelated addresses
    wr(8'h28, 8'h55); wr(8'h00, 8'hFF); wr(8'h23, 8'h07); wr(8'hA7, 8'h01);
    check(ctrlOut == 8'h02, "R10", "ctrlOut after stray writes", int'(ctrlOut), 2);
    waitOvfB(c1); waitOvfB(c2);
    check(c2 - c1 == 4608, "R10", "NB period after stray writes", c2 - c1, 4608);

    // R9: full control byte passes through
    wr(8'h27, 8'h3E);
    check(ctrlOut == 8'h3E, "R9", "ctrlOut full byte", int'(ctrlOut), 8'h3E);

    // both timers together, compared each cycle
    wr(8'h27, 8'h03);
    repeat (6000) @(negedge clk);
    wr(8'h27, 8'h00);
    check(ctrlOut == 8'h00, "R9", "ctrlOut cleared", int'(ctrlOut), 0);
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule